// File: doc/BRIEF.md
# Trigger Event-Type Lookup and Priority Selector

This block turns the raw trigger words of a data acquisition trigger supervisor into a single event-type code. Four narrow trigger groups (two from the backplane trigger processors, two from front-panel external inputs) and one wider front-panel word each address their own lookup table. The tables are loaded through a simple write port before triggers are enabled, and they convert an input bit pattern into a type code. A code of zero means "no trigger from this group".

A fixed-priority selector takes the first non-zero lookup result. The front-panel table wins over all the others, and the four groups follow in index order. A software-commanded trigger with its own type word is used only when no table produced a hit. Narrow group codes are widened to the output width, and the number of the source group is placed in the top bits. The result appears with a valid strobe a fixed two cycles after the trigger strobe.

Top module: `trig_type_lut`

## Requirements
- R1: While reset is held and on the first cycle after reset, `outValid` and `cfgErr` are 0.
- R2: A hit from narrow group g (0 and 1 for the backplane groups, 2 and 3 for the external groups, in the order they are packed into `gtpWords` then `extWords`, lowest bits first) gives `outType[7:0]` = the table code, `outType[8]` = 0 and `outType[10:9]` = g.
- R3: A non-zero front-panel table code is output unchanged as the full 11-bit type and takes priority over every other source.
- R4: Among the narrow groups, the lowest index with a non-zero code wins. Groups whose code is zero are skipped.
- R5: A software trigger (`vmeReq`) outputs `vmeType` only when no table gives a non-zero code in the same cycle. It produces an output even when `trigValid` is low.
- R6: `outValid` is a single-cycle pulse exactly 2 cycles after each accepted trigger cycle. Back-to-back triggers give back-to-back results.
- R7: An accepted `trigValid` with all table codes zero and no `vmeReq` produces no `outValid`.
- R8: A table write while `trigEnable` is 1 leaves every table unchanged. It sets `cfgErr` one cycle later, and `cfgErr` stays set until reset.
- R9: `trigValid` and `vmeReq` are ignored while `trigEnable` is 0.
- R10: A write with `trigEnable` at 0 loads the selected table. `wrSel` 0 to 3 picks a narrow group and uses `wrAddr[6:0]` and `wrData[7:0]`. `wrSel` 4 picks the front-panel table and uses `wrAddr[7:0]` and `wrData[10:0]`. Other `wrSel` values write nothing. A written entry is seen by triggers from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trigEnable | input | 1 | Triggers accepted; table writes refused |
| trigValid | input | 1 | Trigger words are valid this cycle |
| gtpWords | input | 14 | Backplane groups 0 and 1, 7 bits each |
| extWords | input | 14 | External groups 2 and 3, 7 bits each |
| fpWord | input | 8 | Front-panel trigger word |
| vmeReq | input | 1 | Software-commanded trigger |
| vmeType | input | 11 | Type for a software trigger |
| wrEn | input | 1 | Table write strobe |
| wrSel | input | 3 | Table select |
| wrAddr | input | 8 | Table entry address |
| wrData | input | 11 | Code to store |
| outValid | output | 1 | Event type valid |
| outType | output | 11 | Selected event type |
| cfgErr | output | 1 | Sticky refused-write flag |

## Verification
Every event type is due two rising edges after the cycle in which its trigger was accepted. The error flag is due one edge after a refused write. The bench's model computes the expected result at each rising edge from the inputs held there and from its own copy of the tables. It queues the result and compares the entry from two edges earlier against the outputs at the following falling edge. The error flag is compared on every falling edge, one edge after the model updates it.

// File: rtl/trig_lut_pkg.sv
package trig_lut_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic wrAccept;  // table write allowed this cycle
    logic capTrig;   // register lookup results
    logic capVme;    // register software trigger type
    logic s1Trig;    // stage-1 lookup results are live
    logic s1Vme;     // stage-1 software trigger is live
  } lut_strobe_t;

endpackage

// File: rtl/trig_lut_ctrl.sv
module trig_lut_ctrl
  import trig_lut_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trigEnable,
  input  logic        trigValid,
  input  logic        vmeReq,
  input  logic        wrEn,
  input  logic        anyHit,
  output lut_strobe_t strobes,
  output logic        outValid,
  output logic        cfgErr
);

  logic stage1Trig;
  logic stage1Vme;

  always_comb begin
    strobes.wrAccept = wrEn & ~trigEnable;
    strobes.capTrig  = trigValid & trigEnable;
    strobes.capVme   = vmeReq & trigEnable;
    strobes.s1Trig   = stage1Trig;
    strobes.s1Vme    = stage1Vme;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1Trig <= 1'b0;
      stage1Vme  <= 1'b0;
      outValid   <= 1'b0;
      cfgErr     <= 1'b0;
    end else begin
      stage1Trig <= strobes.capTrig;
      stage1Vme  <= strobes.capVme;
      outValid   <= anyHit | stage1Vme;
      if (wrEn && trigEnable) cfgErr <= 1'b1;
    end
  end

endmodule

// File: rtl/trig_lut_datapath.sv
module trig_lut_datapath
  import trig_lut_pkg::*;
#(
  parameter int NUM_GTP = 2,
  parameter int NUM_EXT = 2,
  parameter int GRP_W   = 7,
  parameter int CODE_W  = 8,
  parameter int FP_W    = 8,
  parameter int OUT_W   = 11,
  localparam int NUM_GRP   = NUM_GTP + NUM_EXT,
  localparam int IDX_W     = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1,
  localparam int SEL_W     = $clog2(NUM_GRP + 1),
  localparam int GRP_DEPTH = 1 << GRP_W,
  localparam int FP_DEPTH  = 1 << FP_W
) (
  input  logic                       clk,
  input  logic [NUM_GTP*GRP_W-1:0]   gtpWords,
  input  logic [NUM_EXT*GRP_W-1:0]   extWords,
  input  logic [FP_W-1:0]            fpWord,
  input  logic [OUT_W-1:0]           vmeType,
  input  logic [SEL_W-1:0]           wrSel,
  input  logic [FP_W-1:0]            wrAddr,
  input  logic [OUT_W-1:0]           wrData,
  input  lut_strobe_t                strobes,
  output logic                       anyHit,
  output logic [OUT_W-1:0]           outType
);

  logic [NUM_GRP*GRP_W-1:0] allWords;
  logic [GRP_W-1:0]  grpWord   [NUM_GRP];
  logic [CODE_W-1:0] grpCode   [NUM_GRP];
  logic [OUT_W-1:0]  grpTagged [NUM_GRP];
  logic [NUM_GRP-1:0] hitVec;
  logic [OUT_W-1:0]  fpCode;
  logic [OUT_W-1:0]  vmeReg;
  logic [OUT_W-1:0]  selType;
  logic              fpHit;

  assign allWords = {extWords, gtpWords};

  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : gen_grp
      logic [CODE_W-1:0] table_q [GRP_DEPTH];

      assign grpWord[g] = allWords[g*GRP_W +: GRP_W];

      always_ff @(posedge clk) begin
        if (strobes.wrAccept && wrSel == SEL_W'(g))
          table_q[wrAddr[GRP_W-1:0]] <= wrData[CODE_W-1:0];
        if (strobes.capTrig)
          grpCode[g] <= table_q[grpWord[g]];
      end

      assign hitVec[g]    = strobes.s1Trig & (|grpCode[g]);
      assign grpTagged[g] = OUT_W'(grpCode[g]) | (OUT_W'(g) << (OUT_W - IDX_W));
    end
  endgenerate

  logic [OUT_W-1:0] fpTable [FP_DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrAccept && wrSel == SEL_W'(NUM_GRP))
      fpTable[wrAddr] <= wrData;
    if (strobes.capTrig)
      fpCode <= fpTable[fpWord];
    if (strobes.capVme)
      vmeReg <= vmeType;
  end

  assign fpHit  = strobes.s1Trig & (|fpCode);
  assign anyHit = fpHit | (|hitVec);

  // fixed priority: front panel, then groups by index, software trigger last
  always_comb begin
    selType = vmeReg;
    for (int i = NUM_GRP - 1; i >= 0; i--) begin
      if (hitVec[i]) selType = grpTagged[i];
    end
    if (fpHit) selType = fpCode;
  end

  always_ff @(posedge clk) begin
    if (strobes.s1Trig || strobes.s1Vme) outType <= selType;
  end

endmodule

// File: rtl/trig_type_lut.sv
module trig_type_lut
  import trig_lut_pkg::*;
#(
  parameter int NUM_GTP = 2,
  parameter int NUM_EXT = 2,
  parameter int GRP_W   = 7,
  parameter int CODE_W  = 8,
  parameter int FP_W    = 8,
  parameter int OUT_W   = 11,
  localparam int NUM_GRP = NUM_GTP + NUM_EXT,
  localparam int SEL_W   = $clog2(NUM_GRP + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trigEnable,
  input  logic                     trigValid,
  input  logic [NUM_GTP*GRP_W-1:0] gtpWords,
  input  logic [NUM_EXT*GRP_W-1:0] extWords,
  input  logic [FP_W-1:0]          fpWord,
  input  logic                     vmeReq,
  input  logic [OUT_W-1:0]         vmeType,
  input  logic                     wrEn,
  input  logic [SEL_W-1:0]         wrSel,
  input  logic [FP_W-1:0]          wrAddr,
  input  logic [OUT_W-1:0]         wrData,
  output logic                     outValid,
  output logic [OUT_W-1:0]         outType,
  output logic                     cfgErr
);

  lut_strobe_t strobes;
  logic        anyHit;

  trig_lut_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigEnable (trigEnable),
    .trigValid  (trigValid),
    .vmeReq     (vmeReq),
    .wrEn       (wrEn),
    .anyHit     (anyHit),
    .strobes    (strobes),
    .outValid   (outValid),
    .cfgErr     (cfgErr)
  );

  trig_lut_datapath #(
    .NUM_GTP (NUM_GTP),
    .NUM_EXT (NUM_EXT),
    .GRP_W   (GRP_W),
    .CODE_W  (CODE_W),
    .FP_W    (FP_W),
    .OUT_W   (OUT_W)
  ) u_dp (
    .clk      (clk),
    .gtpWords (gtpWords),
    .extWords (extWords),
    .fpWord   (fpWord),
    .vmeType  (vmeType),
    .wrSel    (wrSel),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strobes  (strobes),
    .anyHit   (anyHit),
    .outType  (outType)
  );

endmodule

// File: rtl/trig_type_lut_chk.sv
module trig_type_lut_chk (
  input logic clk,
  input logic rst_n,
  input logic trigEnable,
  input logic trigValid,
  input logic vmeReq,
  input logic wrEn,
  input logic outValid,
  input logic cfgErr
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1: quiet on the first cycle out of reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst == 2'd0) |-> (!outValid && !cfgErr));

  // R6 / R9: every result traces back to an accepted trigger two cycles earlier
  p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceRst >= 2'd2 && outValid) |->
      $past(trigEnable && (trigValid || vmeReq), 2));

  // R5: an accepted software trigger always yields a result
  p_vme_result_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trigEnable && vmeReq) |=> ##1 outValid);

  // R8: refused write raises the flag
  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && trigEnable) |=> cfgErr);

  // R8: flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfgErr |=> cfgErr);

endmodule

bind trig_type_lut trig_type_lut_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trigEnable (trigEnable),
  .trigValid  (trigValid),
  .vmeReq     (vmeReq),
  .wrEn       (wrEn),
  .outValid   (outValid),
  .cfgErr     (cfgErr)
);

// File: tb/trig_type_lut_bench.sv
module trig_type_lut_bench;

  localparam int NG   = 4;
  localparam int GW   = 7;
  localparam int FW   = 8;
  localparam int OW   = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trigEnable = 1'b0;
  logic trigValid = 1'b0;
  logic [2*GW-1:0] gtpWords = '0;
  logic [2*GW-1:0] extWords = '0;
  logic [FW-1:0] fpWord = '0;
  logic vmeReq = 1'b0;
  logic [OW-1:0] vmeType = '0;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [FW-1:0] wrAddr = '0;
  logic [OW-1:0] wrData = '0;
  logic outValid;
  logic [OW-1:0] outType;
  logic cfgErr;

  always #5 clk = ~clk;

  trig_type_lut u_trig_type_lut (
    .clk(clk), .rst_n(rst_n), .trigEnable(trigEnable), .trigValid(trigValid),
    .gtpWords(gtpWords), .extWords(extWords), .fpWord(fpWord),
    .vmeReq(vmeReq), .vmeType(vmeType), .wrEn(wrEn), .wrSel(wrSel),
    .wrAddr(wrAddr), .wrData(wrData), .outValid(outValid),
    .outType(outType), .cfgErr(cfgErr)
  );

  int checks = 0;
  int errors = 0;

  // reference model state
  int grpTab [NG][128];
  int fpTab [256];
  int qValid [$];
  int qType [$];
  int qSrc [$];   // 0 fp, 1..4 group+1, 5 vme
  bit expErr = 1'b0;

  function automatic int wordOf(int g);
    logic [4*GW-1:0] all;
    all = {extWords, gtpWords};
    return int'(all[g*GW +: GW]);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      qValid.delete(); qType.delete(); qSrc.delete();
      expErr = 1'b0;
    end else begin
      int v, t, s;
      v = 0; t = 0; s = 5;
      if (trigEnable) begin
        if (trigValid) begin
          if (fpTab[fpWord] != 0) begin
            v = 1; t = fpTab[fpWord]; s = 0;
          end else begin
            for (int g = 0; g < NG; g++) begin
              if (v == 0 && grpTab[g][wordOf(g)] != 0) begin
                v = 1; t = grpTab[g][wordOf(g)] + g * 512; s = g + 1;
              end
            end
          end
        end
        if (v == 0 && vmeReq) begin
          v = 1; t = int'(vmeType); s = 5;
        end
      end
      qValid.push_back(v); qType.push_back(t); qSrc.push_back(s);
      if (qValid.size() > 2) begin
        void'(qValid.pop_front()); void'(qType.pop_front()); void'(qSrc.pop_front());
      end
      if (wrEn) begin
        if (trigEnable) expErr = 1'b1;
        else if (wrSel < 3'd4) grpTab[wrSel][wrAddr[GW-1:0]] = int'(wrData[7:0]);
        else if (wrSel == 3'd4) fpTab[wrAddr] = int'(wrData);
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
      check(cfgErr == 1'b0, "R1 cfgErr in reset", int'(cfgErr), 0);
    end else begin
      int ev, et, es;
      ev = 0; et = 0; es = 5;
      if (qValid.size() == 2) begin
        ev = qValid[0]; et = qType[0]; es = qSrc[0];
      end
      check(int'(outValid) == ev, "R6/R7/R9 outValid", int'(outValid), ev);
      if (ev == 1 && outValid) begin
        if (es == 0)      check(int'(outType) == et, "R3 front-panel type", int'(outType), et);
        else if (es == 5) check(int'(outType) == et, "R5 software type", int'(outType), et);
        else              check(int'(outType) == et, "R2/R4 group type", int'(outType), et);
      end
      check(cfgErr == expErr, "R8 cfgErr", int'(cfgErr), int'(expErr));
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic writeTab(input int sel, input int addr, input int data);
    wrEn = 1'b1; wrSel = 3'(sel); wrAddr = FW'(addr); wrData = OW'(data);
    tick();
    wrEn = 1'b0;
  endtask

  task automatic fire(input int g0, input int g1, input int e0, input int e1,
                      input int fp, input bit tv, input bit vr, input int vt);
    trigValid = tv; vmeReq = vr; vmeType = OW'(vt);
    gtpWords = {GW'(g1), GW'(g0)};
    extWords = {GW'(e1), GW'(e0)};
    fpWord = FW'(fp);
    tick();
    trigValid = 1'b0; vmeReq = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    tick();
    // R1: first cycle after reset
    check(outValid == 1'b0 && cfgErr == 1'b0, "R1 after reset", int'(outValid), 0);

    // R10: load every table while disabled
    for (int g = 0; g < NG; g++)
      for (int a = 0; a < 128; a++)
        writeTab(g, a, (a == 0) ? 0 : (((a + g * 32) & 255) | 1));
    for (int a = 0; a < 256; a++)
      writeTab(4, a, (a >= 128) ? (((a * 3) & 2047) | 1) : 0);
    writeTab(6, 9, 0);  // R10: unused select writes nothing
    trigEnable = 1'b1;
    tick();

    fire(0, 0, 0, 0, 5, 1, 0, 0);        idle(3);  // R7 no hit
    fire(3, 0, 0, 0, 200, 1, 0, 0);      idle(3);  // R3 fp wins
    fire(0, 9, 4, 0, 5, 1, 0, 0);        idle(3);  // R4 group 1 over 2
    fire(7, 0, 0, 0, 0, 1, 0, 0);        idle(3);  // R2 group 0
    fire(0, 0, 0, 100, 0, 1, 0, 0);      idle(3);  // R2 group 3 index bits
    fire(0, 0, 0, 0, 0, 1, 1, 11'h3A5);  idle(3);  // R5 software only
    fire(0, 2, 0, 0, 0, 1, 1, 11'h155);  idle(3);  // R5 loses to group 1
    fire(0, 0, 0, 0, 0, 0, 1, 11'h2C3);  idle(3);  // R5 without trigValid
    // R6 back-to-back
    fire(1, 0, 0, 0, 0, 1, 0, 0);
    fire(0, 1, 0, 0, 0, 1, 0, 0);
    fire(0, 0, 1, 0, 0, 1, 0, 0);
    idle(3);

    // R8: refused write, then the old entry is still used
    writeTab(0, 7, 8'h00);
    fire(7, 0, 0, 0, 0, 1, 0, 0);        idle(3);

    // R9: disabled triggers ignored
    trigEnable = 1'b0;
    fire(5, 5, 5, 5, 250, 1, 1, 11'h7FF); idle(3);

    // R10: rewrite entries, used from the next cycle on
    writeTab(0, 7, 8'h55);
    writeTab(4, 130, 11'h000);
    writeTab(3, 100, 8'h00);
    trigEnable = 1'b1;
    fire(7, 0, 0, 0, 130, 1, 0, 0);      idle(3);
    fire(0, 0, 0, 100, 0, 1, 0, 0);      idle(3);

    // mixed stream
    for (int i = 0; i < 400; i++) begin
      int g0, g1, e0, e1, fp;
      g0 = ($urandom % 3 == 0) ? int'($urandom % 128) : 0;
      g1 = ($urandom % 3 == 0) ? int'($urandom % 128) : 0;
      e0 = ($urandom % 3 == 0) ? int'($urandom % 128) : 0;
      e1 = ($urandom % 3 == 0) ? int'($urandom % 128) : 0;
      fp = ($urandom % 4 == 0) ? int'(128 + $urandom % 128) : int'($urandom % 128);
      fire(g0, g1, e0, e1, fp, ($urandom % 4) != 0, ($urandom % 5) == 0,
           int'($urandom % 2048));
    end
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule